// File: doc/BRIEF.md
# Programmable System Clock Divider Controller

This block manages the clock rates of a small microcontroller. It has four clock sources: a precision internal oscillator, a low-power internal oscillator, an external 32.768 kHz watch crystal and the high-speed output of a PLL that is already locked. The block brings each internal oscillator down to the PLL reference rate with a fixed divide-by-4 stage. It routes one of the three references to the PLL. It divides the PLL output by a power of two, set by a register, to form the core clock. It forms the ADC clock from the PLL in normal mode and from the low-power oscillator in low-power mode. It also sends a divide-by-4 tick of the low-power oscillator to the watchdog and wake-up timers.

All logic runs on one fast fabric clock `clk`. Each source arrives as a single-cycle strobe (`*_tick`) that marks one period of that source. Each derived clock leaves as a registered single-cycle enable pulse. To measure a ratio, count the output pulses against the input strobes.

Top module: `sysclk_divctl`

## Requirements
- R1: While `rst` is high at a clock edge, every output pulse is low after that edge. Reset selects the low-power oscillator as PLL reference and sets the core divide exponent to 1, which gives divide-by-2.
- R2: The precision and low-power strobes each pass through a divide-by-4 stage. Every fourth strobe of a source produces one pulse of that stage in the cycle after the strobe. The crystal strobe is not divided and is only registered once.
- R3: `ref_tick` repeats the selected reference one cycle after its stage output, which is two cycles after the source strobe. A write with `sel_wr` sets the selection from `sel_data`: 2'b00 low-power, 2'b01 precision, 2'b10 crystal, 2'b11 low-power. The new selection applies from the cycle after the write.
- R4: `core_tick` pulses once for every 2^CD PLL strobes, with CD from 0 to 7. The pulse comes in the cycle after the PLL strobe that completes the period.
- R5: `cd_wr` may load `cd_data` at any time. The new exponent takes effect only when the current period ends. A write in the same cycle as the terminal strobe sets the very next period.
- R6: In normal mode, `adc_tick` pulses one cycle after every 40th PLL strobe. The divide-by-40 count keeps running in low-power mode.
- R7: `low_power` passes through two synchronizer flops. The ADC source changes to the synchronized value only in a cycle with neither a PLL nor a low-power strobe. While the low-power source is active, `adc_tick` repeats each low-power strobe one cycle later.
- R8: `timer_tick` is the divide-by-4 output of the low-power oscillator. It does not depend on the reference selection or the mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fabric clock |
| rst | input | 1 | Synchronous active-high reset |
| prec_tick | input | 1 | Precision oscillator period strobe |
| lpo_tick | input | 1 | Low-power oscillator period strobe |
| xtal_tick | input | 1 | Watch-crystal period strobe |
| pll_tick | input | 1 | PLL output period strobe |
| sel_wr | input | 1 | Load reference selection |
| sel_data | input | 2 | Reference selection code |
| cd_wr | input | 1 | Load core divide exponent |
| cd_data | input | 3 | Core divide exponent |
| low_power | input | 1 | Low-power mode request (asynchronous) |
| ref_tick | output | 1 | Selected PLL reference pulse |
| core_tick | output | 1 | Core clock enable pulse |
| adc_tick | output | 1 | ADC clock enable pulse |
| timer_tick | output | 1 | Watchdog/wake-up timer enable pulse |

## Verification
Two events can fall in the same cycle: a divide-exponent write and the terminal PLL strobe of the current core period. The bench provokes this by watching its own model of the period count. When the count reaches the terminal value it drives `cd_wr` together with a PLL strobe, then expects two core pulses in adjacent cycles after switching to divide-by-1. The second collision is a mode change arriving while PLL and low-power strobes are dense. Here the reference model accepts the ADC source swap only in a strobe-free cycle, and each cycle's `adc_tick` is compared against the model.

// File: rtl/sysclk_pkg.sv
package sysclk_pkg;
  typedef enum logic [1:0] {
    REF_LPO     = 2'b00,
    REF_PREC    = 2'b01,
    REF_XTAL    = 2'b10,
    REF_LPO_ALT = 2'b11
  } ref_sel_e;
endpackage

// File: rtl/sysclk_prediv.sv
module sysclk_prediv #(
  parameter int DIV = 4
) (
  input  logic clk,
  input  logic rst,
  input  logic tick,
  output logic pulse
);
  localparam int CW = (DIV > 2) ? $clog2(DIV) : 1;
  localparam logic [CW-1:0] LAST = CW'(DIV - 1);

  logic [CW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt   <= '0;
      pulse <= 1'b0;
    end else begin
      pulse <= tick && (cnt == LAST);
      if (tick) cnt <= (cnt == LAST) ? '0 : cnt + CW'(1);
    end
  end
endmodule

// File: rtl/sysclk_core_div.sv
module sysclk_core_div #(
  parameter int CD_W   = 3,
  parameter int CD_RST = 1
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            pll_tick,
  input  logic            cd_wr,
  input  logic [CD_W-1:0] cd_data,
  output logic            core_tick
);
  localparam int CNT_W = (1 << CD_W) - 1;
  localparam int PW    = CNT_W + 1;

  logic [CD_W-1:0]  cd_act, cd_pend;
  logic [CNT_W-1:0] cnt, lim;
  logic [PW-1:0]    pw;
  logic             term;

  always_comb begin
    pw   = PW'(1) << cd_act;
    lim  = CNT_W'(pw - PW'(1));
    term = pll_tick && (cnt == lim);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt       <= '0;
      cd_act    <= CD_W'(CD_RST);
      cd_pend   <= CD_W'(CD_RST);
      core_tick <= 1'b0;
    end else begin
      core_tick <= term;
      if (cd_wr) cd_pend <= cd_data;
      if (term) begin
        cnt    <= '0;
        cd_act <= cd_wr ? cd_data : cd_pend;
      end else if (pll_tick) begin
        cnt <= cnt + CNT_W'(1);
      end
    end
  end
endmodule

// File: rtl/sysclk_adc_clk.sv
module sysclk_adc_clk #(
  parameter int ADC_DIV = 40
) (
  input  logic clk,
  input  logic rst,
  input  logic pll_tick,
  input  logic lpo_tick,
  input  logic low_power,
  output logic adc_tick
);
  localparam int AW = $clog2(ADC_DIV);
  localparam logic [AW-1:0] LAST = AW'(ADC_DIV - 1);

  logic [AW-1:0] acnt;
  logic          sync1, sync2, use_lpo, quiet;

  always_comb quiet = !pll_tick && !lpo_tick;

  always_ff @(posedge clk) begin
    if (rst) begin
      acnt     <= '0;
      sync1    <= 1'b0;
      sync2    <= 1'b0;
      use_lpo  <= 1'b0;
      adc_tick <= 1'b0;
    end else begin
      sync1    <= low_power;
      sync2    <= sync1;
      if (quiet) use_lpo <= sync2;
      adc_tick <= use_lpo ? lpo_tick : (pll_tick && (acnt == LAST));
      if (pll_tick) acnt <= (acnt == LAST) ? '0 : acnt + AW'(1);
    end
  end
endmodule

// File: rtl/sysclk_divctl.sv
module sysclk_divctl
  import sysclk_pkg::*;
#(
  parameter int PRE_DIV = 4,
  parameter int CD_W    = 3,
  parameter int CD_RST  = 1,
  parameter int ADC_DIV = 40
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            prec_tick,
  input  logic            lpo_tick,
  input  logic            xtal_tick,
  input  logic            pll_tick,
  input  logic            sel_wr,
  input  logic [1:0]      sel_data,
  input  logic            cd_wr,
  input  logic [CD_W-1:0] cd_data,
  input  logic            low_power,
  output logic            ref_tick,
  output logic            core_tick,
  output logic            adc_tick,
  output logic            timer_tick
);
  logic     prec_div, lpo_div, xtal_q, ref_nxt;
  ref_sel_e sel_q;

  sysclk_prediv #(.DIV(PRE_DIV)) u_pre_prec (
    .clk(clk), .rst(rst), .tick(prec_tick), .pulse(prec_div));

  sysclk_prediv #(.DIV(PRE_DIV)) u_pre_lpo (
    .clk(clk), .rst(rst), .tick(lpo_tick), .pulse(lpo_div));

  always_comb begin
    case (sel_q)
      REF_PREC: ref_nxt = prec_div;
      REF_XTAL: ref_nxt = xtal_q;
      default:  ref_nxt = lpo_div;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      sel_q    <= REF_LPO;
      xtal_q   <= 1'b0;
      ref_tick <= 1'b0;
    end else begin
      xtal_q   <= xtal_tick;
      ref_tick <= ref_nxt;
      if (sel_wr) sel_q <= ref_sel_e'(sel_data);
    end
  end

  assign timer_tick = lpo_div;

  sysclk_core_div #(.CD_W(CD_W), .CD_RST(CD_RST)) u_core (
    .clk(clk), .rst(rst), .pll_tick(pll_tick), .cd_wr(cd_wr),
    .cd_data(cd_data), .core_tick(core_tick));

  sysclk_adc_clk #(.ADC_DIV(ADC_DIV)) u_adc (
    .clk(clk), .rst(rst), .pll_tick(pll_tick), .lpo_tick(lpo_tick),
    .low_power(low_power), .adc_tick(adc_tick));
endmodule

// File: rtl/sysclk_divctl_chk.sv
module sysclk_divctl_chk (
  input logic clk,
  input logic rst,
  input logic prec_tick,
  input logic lpo_tick,
  input logic xtal_tick,
  input logic pll_tick,
  input logic ref_tick,
  input logic core_tick,
  input logic adc_tick,
  input logic timer_tick
);
  AST_CORE_FROM_PLL: assert property (@(posedge clk) disable iff (rst)
    core_tick |-> $past(pll_tick)); // R4
  AST_TIMER_FROM_LPO: assert property (@(posedge clk) disable iff (rst)
    timer_tick |-> $past(lpo_tick)); // R8
  AST_TIMER_SPACED: assert property (@(posedge clk) disable iff (rst)
    timer_tick |=> !timer_tick); // R2
  AST_ADC_FROM_SRC: assert property (@(posedge clk) disable iff (rst)
    adc_tick |-> ($past(pll_tick) || $past(lpo_tick))); // R6
  AST_REF_FROM_SRC: assert property (@(posedge clk) disable iff (rst)
    ref_tick |-> ($past(prec_tick, 2) || $past(lpo_tick, 2) || $past(xtal_tick, 2))); // R3
endmodule

bind sysclk_divctl sysclk_divctl_chk u_chk (
  .clk(clk), .rst(rst), .prec_tick(prec_tick), .lpo_tick(lpo_tick),
  .xtal_tick(xtal_tick), .pll_tick(pll_tick), .ref_tick(ref_tick),
  .core_tick(core_tick), .adc_tick(adc_tick), .timer_tick(timer_tick));

// File: tb/test_sysclk_divctl.sv
`timescale 1ns/1ps
module test_sysclk_divctl;
  logic clk = 1'b0, rst = 1'b1;
  logic prec_tick = 0, lpo_tick = 0, xtal_tick = 0, pll_tick = 0;
  logic sel_wr = 0, cd_wr = 0, low_power = 0;
  logic [1:0] sel_data = 0;
  logic [2:0] cd_data = 0;
  logic ref_tick, core_tick, adc_tick, timer_tick;
  int n_run = 0, n_fail = 0;
  bit done = 0;

  always #10 clk = ~clk;

  sysclk_divctl i_sysclk_divctl (.*);

  // reference model state
  int m_pc, m_lc, m_cc, m_cd_act, m_cd_pend, m_ac, m_s1, m_s2, m_src, m_sel;
  bit m_pq, m_lq, m_xq, e_ref, e_core, e_adc, e_tmr;

  function automatic int lim_of(int e);
    return (1 << e) - 1;
  endfunction

  always @(posedge clk) begin
    if (rst) begin
      m_pc = 0; m_lc = 0; m_cc = 0; m_cd_act = 1; m_cd_pend = 1; m_ac = 0;
      m_s1 = 0; m_s2 = 0; m_src = 0; m_sel = 0;
      m_pq = 0; m_lq = 0; m_xq = 0;
      e_ref = 0; e_core = 0; e_adc = 0; e_tmr = 0;
    end else begin
      e_ref  = (m_sel == 1) ? m_pq : (m_sel == 2) ? m_xq : m_lq;
      e_core = pll_tick && (m_cc == lim_of(m_cd_act));
      e_adc  = (m_src != 0) ? lpo_tick : (pll_tick && m_ac == 39);
      m_pq = prec_tick && m_pc == 3;
      if (prec_tick) m_pc = (m_pc + 1) % 4;
      m_lq = lpo_tick && m_lc == 3;
      if (lpo_tick) m_lc = (m_lc + 1) % 4;
      e_tmr = m_lq;
      m_xq = xtal_tick;
      if (pll_tick) begin
        if (m_cc == lim_of(m_cd_act)) begin
          m_cc = 0;
          m_cd_act = cd_wr ? int'(cd_data) : m_cd_pend;
        end else m_cc++;
        m_ac = (m_ac == 39) ? 0 : m_ac + 1;
      end
      if (cd_wr) m_cd_pend = int'(cd_data);
      if (sel_wr) m_sel = int'(sel_data);
      if (!pll_tick && !lpo_tick) m_src = m_s2;
      m_s2 = m_s1;
      m_s1 = int'(low_power);
    end
  end

  task automatic check(string req, int act, int exp);
    n_run++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
    end
  endtask

  always @(posedge clk) begin
    #5;
    if (!rst && !done) begin
      check("R3 ref_tick", ref_tick, e_ref);
      check("R4 core_tick", core_tick, e_core);
      check((m_src != 0) ? "R7 adc_tick" : "R6 adc_tick", adc_tick, e_adc);
      check("R8 timer_tick", timer_tick, e_tmr);
    end
  end

  function automatic logic pick(int w);
    case (w)
      0: return ref_tick;
      1: return core_tick;
      2: return adc_tick;
      default: return timer_tick;
    endcase
  endfunction

  // cycles between two consecutive pulses of one output, inputs held
  task automatic gap(int w, output int n);
    n = 0;
    do begin @(posedge clk); #5; end while (!pick(w));
    do begin @(posedge clk); #5; n++; end while (!pick(w) && n < 1000);
  endtask

  task automatic run(int n, int pp, int pl, int pr, int px, bit tog);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      pll_tick  = ($urandom % 100) < pp;
      lpo_tick  = ($urandom % 100) < pl;
      prec_tick = ($urandom % 100) < pr;
      xtal_tick = ($urandom % 100) < px;
      if (tog && ($urandom % 100) < 2) low_power = ~low_power;
    end
  endtask

  task automatic wr_sel(int v);
    @(negedge clk); sel_wr = 1; sel_data = 2'(v);
    @(negedge clk); sel_wr = 0;
  endtask

  task automatic wr_cd(int v);
    @(negedge clk); cd_wr = 1; cd_data = 3'(v);
    @(negedge clk); cd_wr = 0;
  endtask

  initial begin
    int g;
    repeat (4) @(negedge clk);
    // R1: reset state
    check("R1 ref", ref_tick, 0);
    check("R1 core", core_tick, 0);
    check("R1 adc", adc_tick, 0);
    check("R1 timer", timer_tick, 0);
    rst = 0;
    // R1/R5: default divide-by-2 with continuous PLL strobes
    @(negedge clk); pll_tick = 1;
    gap(1, g); check("R5 reset divide 2", g, 2);
    // R3: each selection code under random strobes
    for (int s = 0; s < 4; s++) begin
      wr_sel(s);
      run(400, 60, 50, 50, 30, 0);
    end
    // R2: precision stage ratio with continuous strobes
    wr_sel(1);
    @(negedge clk); prec_tick = 1;
    gap(0, g); check("R2 precision divide 4", g, 4);
    // R4: sweep exponent under random and dense PLL strobes
    for (int e = 0; e < 8; e++) begin
      wr_cd(e);
      run(300, 70, 40, 40, 40, 0);
      run(300, 100, 40, 40, 40, 0);
    end
    @(negedge clk); pll_tick = 1;
    gap(1, g); check("R4 divide 128", g, 128);
    wr_cd(0);
    gap(1, g); gap(1, g); check("R4 divide 1", g, 1);
    // R6: ADC ratio in normal mode
    gap(2, g); check("R6 adc divide 40", g, 40);
    // R5: write coinciding with terminal strobe
    wr_cd(3);
    repeat (20) @(negedge clk);
    while (m_cc != lim_of(m_cd_act)) @(negedge clk);
    cd_wr = 1; cd_data = 3'd0;
    @(posedge clk); #5; check("R5 terminal pulse", core_tick, 1);
    @(negedge clk); cd_wr = 0;
    @(posedge clk); #5; check("R5 new divide at once", core_tick, 1);
    // R7: enter low-power mode, then every low-power strobe reaches ADC
    @(negedge clk); pll_tick = 0; lpo_tick = 0; low_power = 1;
    repeat (4) @(negedge clk);
    lpo_tick = 1;
    gap(2, g); check("R7 adc follows lpo", g, 1);
    gap(3, g); check("R8 timer divide 4", g, 4);
    // R7: random mode toggling under dense strobes
    run(3000, 80, 60, 50, 50, 1);
    low_power = 0;
    run(500, 50, 50, 50, 50, 0);
    done = 1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule